// File: doc/BRIEF.md
# Strobe-Handshake Fall-Through FIFO

This block is a first-in first-out buffer of 64 words of 9 bits. Words are moved by pulsed strobes, not by enables. A pulse on `shift_in` writes one word and a pulse on `shift_out` reads one. Both strobes are ordinary synchronous inputs sampled on `clk`. The block finds their rising and falling edges itself, and each transfer is split across the two edges of one pulse. Two ready outputs work as busy handshakes. `in_rdy` drops while a write pulse is in progress. `out_rdy` drops as soon as a read pulse starts.

The oldest stored word always sits on the output register. Into an empty buffer, a word falls through to the output at the end of its write pulse, even when no read is pending. When the last word has been read, the output keeps showing that word. The fill level is reported as a two-bit code on `lvl_mid` and `lvl_top`. In this code `lvl_mid` really means "neither empty nor full", and `lvl_top` marks the upper half. If a strobe is held high across a full or empty condition, the transfer waits and then completes by itself once the other side frees a place or supplies a word.

`out_en_n` gates the data output. `rd_drive` tells a pad ring or a word-wide neighbour when `rd_data` is driven.

Top module: `strobe_fifo`

## Requirements
- R1: While `rst_n` is low, `in_rdy` is 1 and `out_rdy`, `lvl_mid`, `lvl_top` are 0. The output word is 0 and both pointers return to location 0.
- R2: A strobe event takes effect on the first clock edge at which the sampled strobe differs from its previous sample. On the `shift_in` rising event the input word is captured and `in_rdy` goes low. On the falling event the word is stored, and `in_rdy` returns high unless the buffer now holds 64 words.
- R3: When the buffer is empty, the falling event of a write puts that word on `rd_data` and raises `out_rdy`, with `shift_out` low.
- R4: On a `shift_out` rising event with data present, `out_rdy` goes low. On the falling event the head word is removed and the next word is shown with `out_rdy` high. Words leave in the order they were written.
- R5: After the last word is removed, `out_rdy` stays low and `rd_data` keeps the last word. A `shift_out` pulse on an empty buffer changes nothing.
- R6: The fill code `{lvl_mid,lvl_top}` is 00 for empty, 01 for full, 10 for fewer than 32 words, and 11 for 32 or more words.
- R7: Filling from empty, `lvl_mid` rises on the falling event of the 1st write. `lvl_top` rises on the rising event of the 33rd write. `lvl_mid` falls on the rising event of the 64th write.
- R8: Draining from full, `lvl_mid` rises on the falling event of the 1st read. `lvl_top` falls on the rising event of the 33rd read. `lvl_mid` falls on the falling event of the 64th read.
- R9: A `shift_in` pulse that begins and ends while the buffer is full stores nothing.
- R10: If `shift_in` stays high while the buffer is full, the read falling event frees a place and `in_rdy` and `lvl_mid` go high for one clock. On the next edge the waiting input word is stored and both go low again.
- R11: If `shift_out` stays high while the buffer is empty, an arriving word is shown and `out_rdy` and `lvl_mid` go high for one clock. On the next edge the word is consumed: both go low, the buffer is empty, and `rd_data` keeps the word.
- R12: With `out_en_n` high, `rd_drive` is 0 and `rd_data` is 0. With `out_en_n` low, `rd_drive` is 1 and `rd_data` shows the output word.
- R13: A write falling event and a read falling event on the same edge leave the count unchanged. If a write rising event and a read rising event meet at exactly 32 words, `lvl_top` ends up 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; strobes are sampled on its rising edge |
| rst_n | input | 1 | Active-low master reset, asserted asynchronously |
| wr_data | input | 9 | Word to be written |
| shift_in | input | 1 | Write strobe, one pulse per word |
| shift_out | input | 1 | Read strobe, one pulse per word |
| out_en_n | input | 1 | Active-low output drive enable |
| rd_data | output | 9 | Head word, 0 when not driven |
| rd_drive | output | 1 | High when `rd_data` is being driven |
| in_rdy | output | 1 | Input stage can take a word |
| out_rdy | output | 1 | A valid word is waiting on the output |
| lvl_mid | output | 1 | Fill code bit: neither empty nor full |
| lvl_top | output | 1 | Fill code bit: upper half or full |

## Verification
The main function is tried with a complete fill from empty to 64 words and a complete drain back to empty, checking the handshakes and the fill code after every single edge. This pins the 1st, 33rd and 64th thresholds in both directions. Writes against a full buffer and reads against an empty one show that blocked pulses change nothing. Held strobes across the full and empty boundaries show the one-clock ready pulses and the deferred transfer. Paired write and read pulses at exactly 32 words separate a correct net count and set-over-clear priority from an off-by-one or a lost update.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

  // Phase of one strobe side: idle, pulse accepted, pulse blocked, blocked pulse already served
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_HELD  = 2'd1,
    PH_WAIT  = 2'd2,
    PH_SPENT = 2'd3
  } phase_e;

endpackage

// File: rtl/sfifo_edge.sv
module sfifo_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] strb,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);

  logic [N-1:0] prev_q;

  generate
    for (genvar g = 0; g < N; g++) begin : g_det
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q[g] <= 1'b0;
        else        prev_q[g] <= strb[g];
      end
      assign rise[g] = strb[g] & ~prev_q[g];
      assign fall[g] = ~strb[g] & prev_q[g];
    end
  endgenerate

endmodule

// File: rtl/sfifo_store.sv
module sfifo_store #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_commit,
  input  logic             rd_commit,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] head_nxt
);

  localparam int AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr_q, wr_ptr_d;
  logic [AW-1:0]    rd_ptr_q, rd_ptr_d;

  always_comb begin
    wr_ptr_d = wr_commit ? wr_ptr_q + AW'(1) : wr_ptr_q;
    rd_ptr_d = rd_commit ? rd_ptr_q + AW'(1) : rd_ptr_q;
    // bypass the word being written when it becomes the new head
    if (wr_commit && (wr_ptr_q == rd_ptr_d)) head_nxt = wdata;
    else                                     head_nxt = mem[rd_ptr_d];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_commit) mem[wr_ptr_q] <= wdata;
  end

endmodule

// File: rtl/sfifo_ctrl.sv
module sfifo_ctrl
  import sfifo_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int WIDTH = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             si_rise,
  input  logic             si_fall,
  input  logic             so_rise,
  input  logic             so_fall,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [WIDTH-1:0] head_nxt,
  output logic             wr_commit,
  output logic             rd_commit,
  output logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] dout_q,
  output logic             in_rdy,
  output logic             out_rdy,
  output logic             lvl_mid,
  output logic             lvl_top
);

  localparam int             AW     = $clog2(DEPTH);
  localparam int             CW     = AW + 1;
  localparam logic [CW-1:0]  FULL_C = CW'(DEPTH);
  localparam logic [CW-1:0]  HALF_C = CW'(DEPTH / 2);

  phase_e           in_q, in_d;
  phase_e           out_q, out_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             top_q, top_d;
  logic [WIDTH-1:0] hold_q;
  logic [WIDTH-1:0] dout_d;
  logic             hold_en, direct_sel, set_top, clr_top;
  logic [CW-1:0]    cnt_pend;

  // input side
  always_comb begin
    in_d       = in_q;
    wr_commit  = 1'b0;
    hold_en    = 1'b0;
    direct_sel = 1'b0;
    set_top    = 1'b0;
    unique case (in_q)
      PH_IDLE: if (si_rise) begin
        if (cnt_q != FULL_C) begin
          in_d    = PH_HELD;
          hold_en = 1'b1;
          set_top = (cnt_q >= HALF_C);
        end else begin
          in_d    = PH_WAIT;
        end
      end
      PH_HELD: if (si_fall) begin
        wr_commit = 1'b1;
        in_d      = PH_IDLE;
      end
      PH_WAIT: begin
        if (si_fall) begin
          in_d = PH_IDLE;
        end else if (cnt_q != FULL_C) begin
          wr_commit  = 1'b1;
          direct_sel = 1'b1;
          set_top    = (cnt_q >= HALF_C);
          in_d       = PH_SPENT;
        end
      end
      PH_SPENT: if (si_fall) in_d = PH_IDLE;
      default: in_d = PH_IDLE;
    endcase
  end

  // output side
  always_comb begin
    out_d     = out_q;
    rd_commit = 1'b0;
    clr_top   = 1'b0;
    unique case (out_q)
      PH_IDLE: if (so_rise) begin
        if (cnt_q != '0) begin
          out_d   = PH_HELD;
          clr_top = (cnt_q <= HALF_C);
        end else begin
          out_d   = PH_WAIT;
        end
      end
      PH_HELD: if (so_fall) begin
        rd_commit = 1'b1;
        out_d     = PH_IDLE;
      end
      PH_WAIT: begin
        if (so_fall) begin
          out_d = PH_IDLE;
        end else if (cnt_q != '0) begin
          rd_commit = 1'b1;
          clr_top   = (cnt_q <= HALF_C);
          out_d     = PH_SPENT;
        end
      end
      PH_SPENT: if (so_fall) out_d = PH_IDLE;
      default: out_d = PH_IDLE;
    endcase
  end

  // shared state
  always_comb begin
    wdata  = direct_sel ? wr_data : hold_q;
    cnt_d  = cnt_q + CW'(wr_commit) - CW'(rd_commit);
    top_d  = set_top ? 1'b1 : (clr_top ? 1'b0 : top_q);
    dout_d = (cnt_d != '0) ? head_nxt : dout_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q   <= PH_IDLE;
      out_q  <= PH_IDLE;
      cnt_q  <= '0;
      top_q  <= 1'b0;
      dout_q <= '0;
    end else begin
      in_q   <= in_d;
      out_q  <= out_d;
      cnt_q  <= cnt_d;
      top_q  <= top_d;
      dout_q <= dout_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (hold_en) hold_q <= wr_data;
  end

  assign cnt_pend = cnt_q + CW'(in_q == PH_HELD);
  assign in_rdy   = ((in_q == PH_IDLE) || (in_q == PH_WAIT)) && (cnt_q != FULL_C);
  assign out_rdy  = ((out_q == PH_IDLE) || (out_q == PH_WAIT)) && (cnt_q != '0);
  assign lvl_mid  = (cnt_q != '0) && (cnt_pend != FULL_C);
  assign lvl_top  = top_q;

endmodule

// File: rtl/strobe_fifo.sv
module strobe_fifo #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             shift_in,
  input  logic             shift_out,
  input  logic             out_en_n,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_drive,
  output logic             in_rdy,
  output logic             out_rdy,
  output logic             lvl_mid,
  output logic             lvl_top
);

  localparam int NSTRB = 2;

  logic             rst_meta, rst_sync_n;
  logic [NSTRB-1:0] rise, fall;
  logic             wr_commit, rd_commit;
  logic [WIDTH-1:0] wdata, head_nxt, dout_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  sfifo_edge #(.N(NSTRB)) edge_i (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .strb  ({shift_out, shift_in}),
    .rise  (rise),
    .fall  (fall)
  );

  sfifo_ctrl #(.DEPTH(DEPTH), .WIDTH(WIDTH)) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .si_rise   (rise[0]),
    .si_fall   (fall[0]),
    .so_rise   (rise[1]),
    .so_fall   (fall[1]),
    .wr_data   (wr_data),
    .head_nxt  (head_nxt),
    .wr_commit (wr_commit),
    .rd_commit (rd_commit),
    .wdata     (wdata),
    .dout_q    (dout_q),
    .in_rdy    (in_rdy),
    .out_rdy   (out_rdy),
    .lvl_mid   (lvl_mid),
    .lvl_top   (lvl_top)
  );

  sfifo_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) store_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_commit (wr_commit),
    .rd_commit (rd_commit),
    .wdata     (wdata),
    .head_nxt  (head_nxt)
  );

  assign rd_drive = ~out_en_n;
  assign rd_data  = out_en_n ? '0 : dout_q;

endmodule

// File: rtl/sfifo_chk.sv
module sfifo_chk #(
  parameter int WIDTH = 9
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             shift_in,
  input logic             shift_out,
  input logic             out_en_n,
  input logic [WIDTH-1:0] rd_data,
  input logic             rd_drive,
  input logic             in_rdy,
  input logic             out_rdy,
  input logic             lvl_mid,
  input logic             lvl_top
);

  AST_BUSY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(shift_in) |=> !in_rdy); // R2

  AST_BUSY_ON_READ: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(shift_out) |=> !out_rdy); // R4

  AST_EMPTY_NO_DATA: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!lvl_mid && !lvl_top) |-> !out_rdy); // R6

  AST_FULL_NO_ROOM: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!lvl_mid && lvl_top) |-> !in_rdy); // R9

  AST_EMPTY_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!lvl_mid && !lvl_top && !out_en_n && $past(!lvl_mid && !lvl_top && !out_en_n))
      |-> $stable(rd_data)); // R5

  AST_DRIVE_OFF: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_en_n |-> (!rd_drive && (rd_data == '0))); // R12

endmodule

bind strobe_fifo sfifo_chk #(.WIDTH(WIDTH)) chk_i (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .shift_in   (shift_in),
  .shift_out  (shift_out),
  .out_en_n   (out_en_n),
  .rd_data    (rd_data),
  .rd_drive   (rd_drive),
  .in_rdy     (in_rdy),
  .out_rdy    (out_rdy),
  .lvl_mid    (lvl_mid),
  .lvl_top    (lvl_top)
);

// File: tb/strobe_fifo_tb_top.sv
module strobe_fifo_tb_top;

  localparam int DEPTH = 64;
  localparam int HALF  = DEPTH / 2;
  localparam int WIDTH = 9;

  logic             clk;
  logic             rst_n;
  logic [WIDTH-1:0] wr_data;
  logic             shift_in, shift_out, out_en_n;
  logic [WIDTH-1:0] rd_data;
  logic             rd_drive, in_rdy, out_rdy, lvl_mid, lvl_top;

  int n_chk;
  int n_bad;
  bit done;

  logic [WIDTH-1:0] mq[$];
  logic [WIDTH-1:0] last_w;
  bit               top_e;

  strobe_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_data   (wr_data),
    .shift_in  (shift_in),
    .shift_out (shift_out),
    .out_en_n  (out_en_n),
    .rd_data   (rd_data),
    .rd_drive  (rd_drive),
    .in_rdy    (in_rdy),
    .out_rdy   (out_rdy),
    .lvl_mid   (lvl_mid),
    .lvl_top   (lvl_top)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [WIDTH-1:0] head_e();
    return (mq.size() != 0) ? mq[0] : last_w;
  endfunction

  task automatic chk_idle(input string tag);
    int c = mq.size();
    chk({tag, " in_rdy"},  16'(in_rdy),  16'(c < DEPTH));
    chk({tag, " out_rdy"}, 16'(out_rdy), 16'(c > 0));
    chk({tag, " lvl_mid"}, 16'(lvl_mid), 16'(c != 0 && c != DEPTH));
    chk({tag, " lvl_top"}, 16'(lvl_top), 16'(top_e));
    chk({tag, " rd_data"}, 16'(rd_data), 16'(head_e()));
  endtask

  task automatic edge_wait();
    @(posedge clk);
    #1;
  endtask

  // one write pulse, checked after each of its two edges
  task automatic wr(input logic [WIDTH-1:0] d, input string tag);
    int c = mq.size();
    @(negedge clk); shift_in = 1'b1; wr_data = d;
    edge_wait();
    if (c < DEPTH && c >= HALF) top_e = 1'b1;
    chk({tag, " R2 rise in_rdy"}, 16'(in_rdy), 16'd0);
    chk({tag, " R7 rise lvl_mid"}, 16'(lvl_mid), 16'(c != 0 && c < DEPTH - 1));
    chk({tag, " R7 rise lvl_top"}, 16'(lvl_top), 16'(top_e));
    @(negedge clk); shift_in = 1'b0; wr_data = ~d;
    edge_wait();
    if (c < DEPTH) mq.push_back(d);
    chk_idle({tag, " R2 fall"});
  endtask

  // one read pulse
  task automatic rd(input string tag);
    int c = mq.size();
    @(negedge clk); shift_out = 1'b1;
    edge_wait();
    if (c > 0 && c <= HALF) top_e = 1'b0;
    chk({tag, " R4 rise out_rdy"}, 16'(out_rdy), 16'd0);
    chk({tag, " R8 rise lvl_top"}, 16'(lvl_top), 16'(top_e));
    chk({tag, " R8 rise lvl_mid"}, 16'(lvl_mid), 16'(c != 0 && c != DEPTH));
    @(negedge clk); shift_out = 1'b0;
    edge_wait();
    if (c > 0) last_w = mq.pop_front();
    chk_idle({tag, " R4 fall"});
  endtask

  task automatic fill_to(input int n, input int seed, input string tag);
    while (mq.size() < n) wr(WIDTH'((mq.size() * 37 + seed) & 9'h1ff), tag);
  endtask

  task automatic drain(input string tag);
    while (mq.size() > 0) rd(tag);
  endtask

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    top_e = 1'b0; last_w = '0;
    rst_n = 1'b0; shift_in = 1'b0; shift_out = 1'b0; out_en_n = 1'b0; wr_data = '0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 in_rdy",  16'(in_rdy),  16'd1);
    chk("R1 out_rdy", 16'(out_rdy), 16'd0);
    chk("R1 lvl_mid", 16'(lvl_mid), 16'd0);
    chk("R1 lvl_top", 16'(lvl_top), 16'd0);
    chk("R1 rd_data", 16'(rd_data), 16'd0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R12 output enable, empty
    @(negedge clk); out_en_n = 1'b1; #1;
    chk("R12 drive off", 16'(rd_drive), 16'd0);
    @(negedge clk); out_en_n = 1'b0; #1;
    chk("R12 drive on", 16'(rd_drive), 16'd1);

    // R3 first word falls through with shift_out low
    wr(9'h15a, "R3 first");
    chk("R3 fallthrough rd_data", 16'(rd_data), 16'h15a);
    chk("R3 fallthrough out_rdy", 16'(out_rdy), 16'd1);
    chk("R6 code fewer", 16'({lvl_mid, lvl_top}), 16'b10);

    // R7 fill to full, checking every edge
    fill_to(DEPTH, 5, "R7 fill");
    chk("R6 code full", 16'({lvl_mid, lvl_top}), 16'b01);

    // R9 pulse while full is dropped
    wr(9'h0f0, "R9 blocked");
    chk("R9 head unchanged", 16'(rd_data), 16'h15a);

    // R12 not driven while holding data
    @(negedge clk); out_en_n = 1'b1; #1;
    chk("R12 data zero", 16'(rd_data), 16'd0);
    chk("R12 drive low", 16'(rd_drive), 16'd0);
    @(negedge clk); out_en_n = 1'b0; #1;
    chk("R12 data back", 16'(rd_data), 16'h15a);

    // R8 drain, R4 order
    drain("R8 drain");
    chk("R5 last word kept", 16'(rd_data), 16'(last_w));
    chk("R6 code empty", 16'({lvl_mid, lvl_top}), 16'b00);

    // R5 read on empty
    rd("R5 empty read");

    // R11 shift_out held while empty
    @(negedge clk); shift_out = 1'b1;
    edge_wait();
    @(negedge clk); shift_in = 1'b1; wr_data = 9'h0c3;
    edge_wait();
    chk("R11 busy in", 16'(in_rdy), 16'd0);
    @(negedge clk); shift_in = 1'b0; wr_data = 9'h000;
    edge_wait();
    chk("R11 out_rdy pulse", 16'(out_rdy), 16'd1);
    chk("R11 lvl_mid pulse", 16'(lvl_mid), 16'd1);
    chk("R11 word shown", 16'(rd_data), 16'h0c3);
    edge_wait();
    chk("R11 out_rdy back", 16'(out_rdy), 16'd0);
    chk("R11 lvl_mid back", 16'(lvl_mid), 16'd0);
    chk("R11 word kept", 16'(rd_data), 16'h0c3);
    @(negedge clk); shift_out = 1'b0;
    edge_wait();
    last_w = 9'h0c3;
    chk_idle("R11 settled");
    wr(9'h101, "R11 next");
    chk("R11 consumed once", 16'(rd_data), 16'h101);
    rd("R11 clear");

    // R10 shift_in held while full
    fill_to(DEPTH, 11, "R10 fill");
    @(negedge clk); shift_in = 1'b1; wr_data = 9'h1e7;
    edge_wait();
    chk("R10 wait in_rdy", 16'(in_rdy), 16'd0);
    chk("R10 wait code", 16'({lvl_mid, lvl_top}), 16'b01);
    @(negedge clk); shift_out = 1'b1;
    edge_wait();
    chk("R10 R4 out_rdy", 16'(out_rdy), 16'd0);
    @(negedge clk); shift_out = 1'b0;
    edge_wait();
    last_w = mq.pop_front();
    chk("R10 in_rdy pulse", 16'(in_rdy), 16'd1);
    chk("R10 lvl_mid pulse", 16'(lvl_mid), 16'd1);
    chk("R10 next head", 16'(rd_data), 16'(mq[0]));
    edge_wait();
    mq.push_back(9'h1e7);
    chk("R10 in_rdy back", 16'(in_rdy), 16'd0);
    chk("R10 lvl_mid back", 16'(lvl_mid), 16'd0);
    @(negedge clk); shift_in = 1'b0;
    edge_wait();
    chk_idle("R10 settled");
    drain("R10 drain");
    chk("R10 held word last", 16'(last_w), 16'h1e7);

    // R13 paired pulses at exactly half
    fill_to(HALF, 23, "R13 fill");
    @(negedge clk); shift_in = 1'b1; shift_out = 1'b1; wr_data = 9'h0a5;
    edge_wait();
    top_e = 1'b1;
    chk("R13 top set wins", 16'(lvl_top), 16'd1);
    chk("R13 in busy", 16'(in_rdy), 16'd0);
    chk("R13 out busy", 16'(out_rdy), 16'd0);
    @(negedge clk); shift_in = 1'b0; shift_out = 1'b0;
    edge_wait();
    last_w = mq.pop_front();
    mq.push_back(9'h0a5);
    chk_idle("R13 net count");
    drain("R13 drain");
    chk("R13 paired word last", 16'(last_w), 16'h0a5);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    done = 1'b1;
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_bad++;
      $display("FAIL all watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule